// File: doc/BRIEF.md
# Sized Byte-Field Reader

This block takes a byte stream and turns a run of one to four consecutive bytes into a single 32-bit operand. A 3-bit control word travels with each request. Its low two bits hold the byte count minus one. Its top bit chooses whether the unused upper bits are filled with copies of the field's top bit (signed) or with zeros (unsigned). One unit therefore covers 8-, 16-, 24- and 32-bit reads, in both signed and unsigned forms. The plain byte, word and long fetches are the unsigned cases with counts of one, two and four.

A request is accepted on a valid/ready command port. The block then pulls exactly the requested number of bytes from a valid/ready byte port and places them little-endian. It presents the assembled result for one cycle, together with a carry flag and a zero flag. The carry flag holds the most significant bit of the field that was read. The zero flag reports a zero result.

The sequencer has three states. ST_IDLE accepts a command (transition `accept`) and moves to ST_COLLECT. ST_COLLECT takes one byte on each byte handshake. It stays in ST_COLLECT (transition `take`) until the last byte of the field, then moves to ST_DONE (transition `last`). ST_DONE drives the result for one cycle and returns to ST_IDLE (transition `retire`).

Top module: `sized_field_reader`

## Requirements
- R1: Exactly cmd_ctrl[1:0]+1 bytes are consumed per command. byte_ready is low in every cycle outside ST_COLLECT, so no extra byte is taken.
- R2: Bytes are placed little-endian: the first byte received occupies res_data[7:0], the second [15:8], the third [23:16] and the fourth [31:24].
- R3: With cmd_ctrl[2]=0, every result bit above the field is zero.
- R4: With cmd_ctrl[2]=1, every result bit above the field equals the field's most significant bit.
- R5: res_carry equals bit 7, 15, 23 or 31 of the assembled field, for 1, 2, 3 or 4 bytes, whatever the extension mode.
- R6: res_zero is 1 exactly when the 32-bit res_data is zero.
- R7: For a 4-byte read, cmd_ctrl[2] does not change res_data.
- R8: cmd_ready is high only in ST_IDLE. A command presented while a read is in progress is neither accepted nor allowed to change the read in progress.
- R9: res_valid is high for exactly one cycle, the cycle right after the clock edge that takes the last byte.
- R10: After reset, cmd_ready=1, byte_ready=0 and res_valid=0.
- R11: Cycles with byte_valid low during a read only delay the result and do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (idle) |
| cmd_ctrl | input | 3 | [1:0] byte count minus one, [2] sign-extend enable |
| byte_valid | input | 1 | Stream byte offered |
| byte_ready | output | 1 | Stream byte can be taken |
| byte_data | input | 8 | Stream byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 32 | Assembled and extended result |
| res_carry | output | 1 | Most significant bit of the field read |
| res_zero | output | 1 | Result equals zero |

## Verification
The bound checker watches every cycle. It checks that the number of bytes taken matches the latched count, that the result strobe follows the last byte and lasts a single cycle, that the command and byte ports are never ready together, and that the bits above the field follow the chosen extension mode and the carry. The bench's scenarios show the rest. These include the little-endian lane order for known byte patterns, the zero flag on real zero and non-zero values, sign control having no effect on a full-width read, a command ignored while busy, and results that stay the same when the stream stalls.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DONE    = 2'd2
    } sfr_state_e;
endpackage

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
    import sfr_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [IDX_W-1:0] cmd_len,
    input  logic             cmd_sign,
    input  logic             byte_valid,
    output logic             cmd_ready,
    output logic             byte_ready,
    output logic             accept,
    output logic             take,
    output logic [IDX_W-1:0] lane_idx,
    output logic [IDX_W-1:0] len_q,
    output logic             sign_q,
    output logic             done
);
    sfr_state_e state, state_nx;

    // state register and operand latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lane_idx <= '0;
            len_q    <= '0;
            sign_q   <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                lane_idx <= '0;
                len_q    <= cmd_len;
                sign_q   <= cmd_sign;
            end else if (take) begin
                lane_idx <= lane_idx + 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_nx   = state;
        cmd_ready  = 1'b0;
        byte_ready = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) state_nx = ST_COLLECT;
            end
            ST_COLLECT: begin
                byte_ready = 1'b1;
                if (byte_valid && lane_idx == len_q) state_nx = ST_DONE;
            end
            ST_DONE: begin
                done     = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
        accept = cmd_ready && cmd_valid;
        take   = byte_ready && byte_valid;
    end
endmodule

// File: rtl/sfr_assemble.sv
module sfr_assemble #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    parameter int IDX_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      take,
    input  logic [IDX_W-1:0]          lane_idx,
    input  logic [BYTE_W-1:0]         data_in,
    output logic [BYTE_W*LANES-1:0]   field
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [IDX_W-1:0] LANE_ID = IDX_W'(i);
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                field[i*BYTE_W +: BYTE_W] <= '0;
            end else if (take && lane_idx == LANE_ID) begin
                field[i*BYTE_W +: BYTE_W] <= data_in;
            end
        end
    end
endmodule

// File: rtl/sfr_extend.sv
module sfr_extend #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    parameter int IDX_W  = 2
) (
    input  logic [BYTE_W*LANES-1:0] field,
    input  logic [IDX_W-1:0]        len,
    input  logic                    sign,
    output logic [BYTE_W*LANES-1:0] result,
    output logic                    carry,
    output logic                    zero
);
    // pick the top bit of the highest lane that was read
    always_comb begin
        carry = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (len == IDX_W'(i)) carry = field[i*BYTE_W + BYTE_W - 1];
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_fill
        localparam logic [IDX_W-1:0] LANE_ID = IDX_W'(i);
        assign result[i*BYTE_W +: BYTE_W] = (LANE_ID <= len) ?
            field[i*BYTE_W +: BYTE_W] : {BYTE_W{sign & carry}};
    end

    assign zero = (result == '0);
endmodule

// File: rtl/sized_field_reader.sv
module sized_field_reader #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int IDX_W  = $clog2(LANES),
    localparam int CTRL_W = IDX_W + 1,
    localparam int DATA_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CTRL_W-1:0] cmd_ctrl,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_carry,
    output logic              res_zero
);
    logic             accept, take, sign_q;
    logic [IDX_W-1:0] lane_idx, len_q;
    logic [DATA_W-1:0] field;

    sfr_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_len    (cmd_ctrl[IDX_W-1:0]),
        .cmd_sign   (cmd_ctrl[IDX_W]),
        .byte_valid (byte_valid),
        .cmd_ready  (cmd_ready),
        .byte_ready (byte_ready),
        .accept     (accept),
        .take       (take),
        .lane_idx   (lane_idx),
        .len_q      (len_q),
        .sign_q     (sign_q),
        .done       (res_valid)
    );

    sfr_assemble #(.BYTE_W(BYTE_W), .LANES(LANES), .IDX_W(IDX_W)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .take     (take),
        .lane_idx (lane_idx),
        .data_in  (byte_data),
        .field    (field)
    );

    sfr_extend #(.BYTE_W(BYTE_W), .LANES(LANES), .IDX_W(IDX_W)) u_ext (
        .field  (field),
        .len    (len_q),
        .sign   (sign_q),
        .result (res_data),
        .carry  (res_carry),
        .zero   (res_zero)
    );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int IDX_W  = $clog2(LANES),
    localparam int CTRL_W = IDX_W + 1,
    localparam int DATA_W = BYTE_W * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [CTRL_W-1:0] cmd_ctrl,
    input logic              byte_valid,
    input logic              byte_ready,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              res_carry
);
    logic [IDX_W-1:0] cap_len;
    logic             cap_sign;
    logic [IDX_W:0]   taken;
    logic [DATA_W-1:0] fmask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_len  <= '0;
            cap_sign <= 1'b0;
            taken    <= '0;
        end else if (cmd_valid && cmd_ready) begin
            cap_len  <= cmd_ctrl[IDX_W-1:0];
            cap_sign <= cmd_ctrl[IDX_W];
            taken    <= '0;
        end else if (byte_valid && byte_ready) begin
            taken <= taken + 1'b1;
        end
    end

    always_comb begin
        fmask = '0;
        for (int i = 0; i < LANES; i++) begin
            if (IDX_W'(i) <= cap_len) fmask[i*BYTE_W +: BYTE_W] = '1;
        end
    end

    assert_byte_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> taken == {1'b0, cap_len} + 1'b1);
    assert_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !cap_sign |-> (res_data & ~fmask) == '0);
    assert_sign_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && cap_sign && res_carry |-> (res_data | fmask) == '1);
    assert_sign_zeros_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && cap_sign && !res_carry |-> (res_data & ~fmask) == '0);
    assert_ports_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && byte_ready) && !(cmd_ready && res_valid));
    assert_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && byte_ready && taken == {1'b0, cap_len} |=> res_valid);
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

bind sized_field_reader sfr_checker #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_ctrl   (cmd_ctrl),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .res_carry  (res_carry)
);

// File: tb/tb_sized_field_reader.sv
`timescale 1ns/1ps
module tb_sized_field_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_ctrl = '0;
    logic        byte_valid = 1'b0;
    logic        byte_ready;
    logic [7:0]  byte_data = '0;
    logic        res_valid;
    logic [31:0] res_data;
    logic        res_carry;
    logic        res_zero;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    sized_field_reader dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_ctrl(cmd_ctrl),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
        .res_valid(res_valid), .res_data(res_data),
        .res_carry(res_carry), .res_zero(res_zero)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected value derived from the requirements
    function automatic logic [32:0] model(input logic [2:0] ctrl, input logic [31:0] raw);
        logic [31:0] mask, f;
        logic        msb;
        int          nb;
        nb   = int'(ctrl[1:0]) + 1;
        mask = (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (nb*8)) - 1);
        f    = raw & mask;
        msb  = f[nb*8-1];
        if (ctrl[2] && msb) f = f | ~mask;
        return {msb, f};
    endfunction

    // one complete read; gap inserts idle stream cycles, busy offers a stray command
    task automatic run_read(input string tag, input logic [2:0] ctrl,
                            input logic [31:0] raw, input int gap, input bit busy);
        logic [32:0] exp;
        int nb;
        exp = model(ctrl, raw);
        nb  = int'(ctrl[1:0]) + 1;
        @(negedge clk);
        chk("R8 ready in idle", 32'(cmd_ready), 32'd1);
        cmd_valid = 1'b1;
        cmd_ctrl  = ctrl;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = busy;
        cmd_ctrl  = ~ctrl;
        for (int i = 0; i < nb; i++) begin
            for (int g = 0; g < gap; g++) begin
                byte_valid = 1'b0;
                @(negedge clk);
                chk("R11 no strobe while stalled", 32'(res_valid), 32'd0);
            end
            if (busy) chk("R8 busy refuses command", 32'(cmd_ready), 32'd0);
            chk("R1 ready while collecting", 32'(byte_ready), 32'd1);
            byte_valid = 1'b1;
            byte_data  = raw[i*8 +: 8];
            @(posedge clk);
            @(negedge clk);
        end
        byte_valid = 1'b1;
        byte_data  = 8'hA5;
        chk({tag, " R9 strobe after last byte"}, 32'(res_valid), 32'd1);
        chk({tag, " R1 no extra byte"}, 32'(byte_ready), 32'd0);
        chk({tag, " R2 R3 R4 data"}, res_data, exp[31:0]);
        chk({tag, " R5 carry"}, 32'(res_carry), 32'(exp[32]));
        chk({tag, " R6 zero"}, 32'(res_zero), 32'(exp[31:0] == 32'd0));
        cmd_valid  = 1'b0;
        byte_valid = 1'b0;
        @(negedge clk);
        chk({tag, " R9 single cycle"}, 32'(res_valid), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 cmd_ready", 32'(cmd_ready), 32'd1);
        chk("R10 byte_ready", 32'(byte_ready), 32'd0);
        chk("R10 res_valid", 32'(res_valid), 32'd0);
    endtask

    task automatic t_unsigned();
        run_read("R3 byte",  3'b000, 32'h1122_33F4, 0, 0);
        run_read("R3 word",  3'b001, 32'h1122_8301, 0, 0);
        run_read("R3 three", 3'b010, 32'h77A2_0304, 0, 0);
        run_read("R2 long",  3'b011, 32'h8877_6655, 0, 0);
    endtask

    task automatic t_signed();
        run_read("R4 byte neg",  3'b100, 32'h0000_0080, 0, 0);
        run_read("R4 byte pos",  3'b100, 32'hFFFF_FF7F, 0, 0);
        run_read("R4 word neg",  3'b101, 32'h0000_F00D, 0, 0);
        run_read("R4 three neg", 3'b110, 32'h00C0_FFEE, 0, 0);
        run_read("R4 three pos", 3'b110, 32'hFF12_3456, 0, 0);
    endtask

    task automatic t_long_sign();
        run_read("R7 long signed",   3'b111, 32'hDEAD_BEEF, 0, 0);
        run_read("R7 long unsigned", 3'b011, 32'hDEAD_BEEF, 0, 0);
    endtask

    task automatic t_zero_flag();
        run_read("R6 zero byte", 3'b100, 32'hFFFF_FF00, 0, 0);
        run_read("R6 zero long", 3'b011, 32'h0000_0000, 0, 0);
    endtask

    task automatic t_busy();
        run_read("R8 busy word", 3'b001, 32'h0000_1234, 0, 1);
    endtask

    task automatic t_stall();
        run_read("R11 stall three", 3'b110, 32'h0081_2233, 2, 0);
        run_read("R11 stall long",  3'b111, 32'h0102_0304, 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unsigned();
        t_signed();
        t_long_sign();
        t_zero_flag();
        t_busy();
        t_stall();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule